// File: doc/BRIEF.md
# Wildcard Memory-Mapped Cell Access Port

This block is the processor-side random-access port into a small grid of logic cells. Each cell carries one configuration byte and one user flip-flop. A processor drives a synchronous bus made of an address, a write enable and write data. It gets back registered read data one cycle later. The data width is a parameter and may be 8, 16 or 32 bits. Configuration bytes and user flip-flops live in a single address space, which the top two address bits split into four regions.

Two features let one bus cycle do more than a plain memory access. In a column access, a row-select register picks some rows of one grid column. The flip-flops of those rows are packed onto the low data bits on a read, and unpacked from them on a write. A don't-care register names address-field bits to ignore on writes. A single write cycle then lands on every matching configuration word, flip-flop or column at once. Typical uses are broadcasting a configuration pattern across a bit-sliced layout, or loading one value into many registers.

Top module: `wild_map_port`

## Requirements
- R1: While reset is asserted and after its release, every configuration byte, every user flip-flop, the row-select register, the don't-care register and the read data are zero.
- R2: The address is {region[1:0], field[5:0]}. In region 0 the field is a word index w. Word w holds the configuration bytes of cells w*NB .. w*NB+NB-1, with NB = data width / 8. Cell w*NB+k sits on data bits [8k+7:8k]. One write updates all NB cells of a word, and a read returns them.
- R3: In region 1 the field is the cell index row*COLS+col. A write stores wdata[0] into that cell's flip-flop. A read returns it on bit 0, with every other bit zero.
- R4: In region 2 the field is a column number. A read packs the flip-flops of the rows whose row-select bit is 1 onto data bits 0, 1, 2 and so on, taking rows in ascending order. The remaining data bits are zero.
- R5: A region 2 write gives the selected rows, in ascending row order, the consecutive wdata bits starting at bit 0. Flip-flops in rows whose row-select bit is 0 keep their value.
- R6: Each 1 in the don't-care register makes the same field bit a don't-care for writes to regions 0, 1 and 2. Every matching word, cell or column is written in the same cycle.
- R7: Reads always use the exact address. The don't-care register has no effect on them.
- R8: In region 3, field 0 is the row-select register (ROWS bits) and field 1 is the don't-care register (6 bits). Both are readable and writable. Writes to region 3 ignore the don't-care register. Other region 3 fields read zero and ignore writes.
- R9: Read data shows the location addressed at the previous clock edge, as it stood before any write in that same cycle.
- R10: A write takes effect at the clock edge that samples wr_en. A read issued in the next cycle returns the new value.
- R11: Region 0 and region 2 fields beyond the existing words or columns read zero and, with no don't-care bits set, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Region (bits 7:6) and field (bits 5:0) |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Registered read data |

## Verification
The bench aims at the packing order of sparse row selections. A design that kept bit positions equal to row numbers, or packed rows from the top, would return scattered or reversed bits, and on writes it would clobber unselected rows. Broadcast writes are checked with don't-care bits on word, cell and column fields. A matcher that ignored the mask would touch a single location, and one that also masked reads would return merged data. The bench also reads a location in the same cycle it is written, to catch read data that bypasses the write. It writes the control region while don't-care bits are set, to catch a mask that leaks into register writes.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

    typedef enum logic [1:0] {
        RG_CFG = 2'd0,
        RG_FF  = 2'd1,
        RG_COL = 2'd2,
        RG_CTL = 2'd3
    } region_e;

    localparam int CTL_SEL  = 0;
    localparam int CTL_WILD = 1;

    // Field comparison with don't-care bits
    function automatic logic fld_hit(input logic [15:0] fld,
                                     input logic [15:0] tgt,
                                     input logic [15:0] dc);
        return ((fld ^ tgt) & ~dc) == 16'd0;
    endfunction

endpackage

// File: rtl/wcp_ctrl_regs.sv
module wcp_ctrl_regs #(
    parameter int ROWS  = 8,
    parameter int FLD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic             wild_wr,
    input  logic [ROWS-1:0]  sel_in,
    input  logic [FLD_W-1:0] wild_in,
    output logic [ROWS-1:0]  sel_q,
    output logic [FLD_W-1:0] wild_q
);

    typedef struct packed {
        logic [ROWS-1:0]  sel;
        logic [FLD_W-1:0] wild;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (sel_wr)  c_d.sel  = sel_in;
        if (wild_wr) c_d.wild = wild_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sel_q  = c_q.sel;
    assign wild_q = c_q.wild;

    AST_SEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> sel_q == $past(sel_in));  // R8
    AST_WILD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wild_wr |=> $stable(wild_q));  // R8

endmodule

// File: rtl/wcp_decode.sv
module wcp_decode
    import wcp_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int NB    = 4,
    parameter int FLD_W = 6,
    localparam int CELLS = ROWS * COLS,
    localparam int WORDS = CELLS / NB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       region,
    input  logic [FLD_W-1:0] fld,
    input  logic [FLD_W-1:0] wild,
    output logic [WORDS-1:0] cfg_wr_hit,
    output logic [CELLS-1:0] ff_wr_hit,
    output logic [COLS-1:0]  col_wr_hit,
    output logic             sel_wr,
    output logic             wild_wr
);

    logic wr_cfg, wr_ff, wr_col, wr_ctl;

    assign wr_cfg = wr_en && (region == RG_CFG);
    assign wr_ff  = wr_en && (region == RG_FF);
    assign wr_col = wr_en && (region == RG_COL);
    assign wr_ctl = wr_en && (region == RG_CTL);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign cfg_wr_hit[w] = wr_cfg && fld_hit(16'(fld), 16'(w), 16'(wild));
    end

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        assign ff_wr_hit[i] = wr_ff && fld_hit(16'(fld), 16'(i), 16'(wild));
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_wr_hit[c] = wr_col && fld_hit(16'(fld), 16'(c), 16'(wild));
    end

    // control registers always decode the exact field
    assign sel_wr  = wr_ctl && (fld == FLD_W'(CTL_SEL));
    assign wild_wr = wr_ctl && (fld == FLD_W'(CTL_WILD));

    AST_CFG_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wild == '0) |-> $onehot0(cfg_wr_hit));  // R2
    AST_FF_BROADCAST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ff |-> ($countones(ff_wr_hit) == (1 << $countones(wild))));  // R6

endmodule

// File: rtl/wcp_col_pack.sv
module wcp_col_pack #(
    parameter int ROWS  = 8,
    parameter int BUS_W = 32
) (
    input  logic [ROWS-1:0]  sel,
    input  logic [ROWS-1:0]  col_bits,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] packed_rd,
    output logic [ROWS-1:0]  row_wr
);

    always_comb begin
        int pos;
        pos       = 0;
        packed_rd = '0;
        row_wr    = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (sel[r]) begin
                packed_rd[pos] = col_bits[r];
                row_wr[r]      = wdata[pos];
                pos            = pos + 1;
            end
        end
    end

endmodule

// File: rtl/wild_map_port.sv
module wild_map_port
    import wcp_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int BUS_W = 32,
    localparam int CELLS  = ROWS * COLS,
    localparam int NB     = BUS_W / 8,
    localparam int WORDS  = CELLS / NB,
    localparam int CELL_W = $clog2(CELLS),
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int FLD_W  = CELL_W,
    localparam int ADDR_W = FLD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);

    if (!(BUS_W == 8 || BUS_W == 16 || BUS_W == 32) || ROWS > BUS_W) begin : g_bad_cfg
        $error("wild_map_port: BUS_W must be 8, 16 or 32 and not below ROWS");
    end

    typedef struct packed {
        logic [CELLS-1:0][7:0] cfg;
        logic [CELLS-1:0]      ff;
        logic [BUS_W-1:0]      rdata;
    } state_t;

    state_t s_d, s_q;

    logic [1:0]       rg;
    logic [FLD_W-1:0] fld;
    logic [ROWS-1:0]  sel_q;
    logic [FLD_W-1:0] wild_q;
    logic [WORDS-1:0] cfg_wr_hit;
    logic [CELLS-1:0] ff_wr_hit;
    logic [COLS-1:0]  col_wr_hit;
    logic             sel_wr, wild_wr;
    logic [ROWS-1:0]  col_rd_bits;
    logic [BUS_W-1:0] col_packed;
    logic [ROWS-1:0]  row_wr;
    logic [COL_W-1:0] col_sel;

    assign rg      = addr[ADDR_W-1 -: 2];
    assign fld     = addr[FLD_W-1:0];
    assign col_sel = fld[COL_W-1:0];

    wcp_decode #(
        .ROWS (ROWS),
        .COLS (COLS),
        .NB   (NB),
        .FLD_W(FLD_W)
    ) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .region    (rg),
        .fld       (fld),
        .wild      (wild_q),
        .cfg_wr_hit(cfg_wr_hit),
        .ff_wr_hit (ff_wr_hit),
        .col_wr_hit(col_wr_hit),
        .sel_wr    (sel_wr),
        .wild_wr   (wild_wr)
    );

    wcp_ctrl_regs #(
        .ROWS (ROWS),
        .FLD_W(FLD_W)
    ) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (sel_wr),
        .wild_wr(wild_wr),
        .sel_in (wdata[ROWS-1:0]),
        .wild_in(wdata[FLD_W-1:0]),
        .sel_q  (sel_q),
        .wild_q (wild_q)
    );

    // column picked by the read address
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            col_rd_bits[r] = s_q.ff[CELL_W'(r * COLS) + CELL_W'(col_sel)];
        end
    end

    wcp_col_pack #(
        .ROWS (ROWS),
        .BUS_W(BUS_W)
    ) i_pack (
        .sel      (sel_q),
        .col_bits (col_rd_bits),
        .wdata    (wdata),
        .packed_rd(col_packed),
        .row_wr   (row_wr)
    );

    always_comb begin
        logic [BUS_W-1:0]  rd;
        logic [CELL_W-1:0] ci;
        s_d = s_q;
        rd  = '0;
        ci  = '0;

        // configuration words, possibly broadcast
        for (int w = 0; w < WORDS; w++) begin
            if (cfg_wr_hit[w]) begin
                for (int k = 0; k < NB; k++) begin
                    s_d.cfg[w * NB + k] = wdata[8 * k +: 8];
                end
            end
        end

        // single flip-flop writes, possibly broadcast
        for (int i = 0; i < CELLS; i++) begin
            if (ff_wr_hit[i]) s_d.ff[i] = wdata[0];
        end

        // column scatter over selected rows
        for (int c = 0; c < COLS; c++) begin
            if (col_wr_hit[c]) begin
                for (int r = 0; r < ROWS; r++) begin
                    if (sel_q[r]) s_d.ff[r * COLS + c] = row_wr[r];
                end
            end
        end

        // exact-address read of the pre-write state
        case (rg)
            RG_CFG: begin
                if (int'(fld) < WORDS) begin
                    for (int k = 0; k < NB; k++) begin
                        ci = CELL_W'(fld[WORD_W-1:0]) * CELL_W'(NB) + CELL_W'(k);
                        rd[8 * k +: 8] = s_q.cfg[ci];
                    end
                end
            end
            RG_FF: begin
                if (int'(fld) < CELLS) rd[0] = s_q.ff[fld];
            end
            RG_COL: begin
                if (int'(fld) < COLS) rd = col_packed;
            end
            default: begin
                if (fld == FLD_W'(CTL_SEL))       rd = BUS_W'(sel_q);
                else if (fld == FLD_W'(CTL_WILD)) rd = BUS_W'(wild_q);
            end
        endcase
        s_d.rdata = rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.rdata;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rg == RG_CTL && fld == FLD_W'(CTL_SEL) && !wr_en) |=> rdata == BUS_W'(sel_q));  // R9

    for (genvar w = 0; w < WORDS; w++) begin : g_cfg_chk
        AST_CFG_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_wr_hit[w] |=> $stable(s_q.cfg[w * NB +: NB]));  // R6
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        for (genvar c = 0; c < COLS; c++) begin : g_col_chk
            AST_UNMAPPED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (col_wr_hit[c] && !sel_q[r]) |=> s_q.ff[r * COLS + c] == $past(s_q.ff[r * COLS + c]));  // R5
        end
    end

endmodule

// File: tb/test_wild_map_port.sv
module test_wild_map_port;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS   = 8;
    localparam int COLS   = 8;
    localparam int BUS_W  = 32;
    localparam int CELLS  = ROWS * COLS;
    localparam int NB     = BUS_W / 8;
    localparam int WORDS  = CELLS / NB;
    localparam int FLD_W  = 6;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [BUS_W-1:0]  wdata = '0;
    logic [BUS_W-1:0]  rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wild_map_port #(.ROWS(ROWS), .COLS(COLS), .BUS_W(BUS_W)) i_wild_map_port (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wr_en(wr_en),
        .wdata(wdata),
        .rdata(rdata)
    );

    // reference model built from the requirements
    logic [7:0]       cfg_m [CELLS];
    logic             ff_m  [CELLS];
    logic [ROWS-1:0]  sel_m;
    logic [FLD_W-1:0] wild_m;

    logic [BUS_W-1:0] exp_q [$];
    string            tag_q [$];
    int               n_chk = 0;
    int               n_bad = 0;
    logic             pend = 1'b0;
    logic             cap = 1'b0;

    function automatic logic [ADDR_W-1:0] ad(input logic [1:0] rg, input int f);
        return {rg, 6'(f)};
    endfunction

    task automatic check(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] model_rd(input logic [ADDR_W-1:0] a);
        logic [BUS_W-1:0] v;
        logic [1:0]       rg;
        int               f, pos;
        v   = '0;
        rg  = a[7:6];
        f   = int'(a[5:0]);
        pos = 0;
        case (rg)
            2'd0: if (f < WORDS) for (int k = 0; k < NB; k++) v[8*k +: 8] = cfg_m[f*NB + k];
            2'd1: v[0] = ff_m[f];
            2'd2: if (f < COLS) begin
                for (int r = 0; r < ROWS; r++) begin
                    if (sel_m[r]) begin
                        v[pos] = ff_m[r*COLS + f];
                        pos++;
                    end
                end
            end
            default: begin
                if (f == 0)      v = BUS_W'(sel_m);
                else if (f == 1) v = BUS_W'(wild_m);
            end
        endcase
        return v;
    endfunction

    function automatic void model_wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
        logic [1:0]       rg;
        logic [FLD_W-1:0] f;
        int               pos;
        rg = a[7:6];
        f  = a[5:0];
        case (rg)
            2'd0: for (int w = 0; w < WORDS; w++)
                if (((6'(w) ^ f) & ~wild_m) == 6'd0)
                    for (int k = 0; k < NB; k++) cfg_m[w*NB + k] = d[8*k +: 8];
            2'd1: for (int i = 0; i < CELLS; i++)
                if (((6'(i) ^ f) & ~wild_m) == 6'd0) ff_m[i] = d[0];
            2'd2: for (int c = 0; c < COLS; c++) begin
                if (((6'(c) ^ f) & ~wild_m) == 6'd0) begin
                    pos = 0;
                    for (int r = 0; r < ROWS; r++) begin
                        if (sel_m[r]) begin
                            ff_m[r*COLS + c] = d[pos];
                            pos++;
                        end
                    end
                end
            end
            default: begin
                if (f == 6'd0)      sel_m  = d[ROWS-1:0];
                else if (f == 6'd1) wild_m = d[FLD_W-1:0];
            end
        endcase
    endfunction

    // driver: one bus cycle, expected read pushed to the scoreboard
    task automatic op(input logic w, input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d, input string tag);
        @(negedge clk);
        addr  = a;
        wr_en = w;
        wdata = d;
        pend  = 1'b1;
        exp_q.push_back(model_rd(a));
        tag_q.push_back(w ? "R9" : tag);
        if (w) model_wr(a, d);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
        op(1'b1, a, d, "R9");
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        op(1'b0, a, '0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            pend  = 1'b0;
        end
    endtask

    // monitor
    always @(posedge clk) cap <= pend;

    always @(negedge clk) begin
        if (cap) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL scoreboard: result with no expected item, actual %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < CELLS; i++) begin
            cfg_m[i] = 8'h00;
            ff_m[i]  = 1'b0;
        end
        sel_m  = '0;
        wild_m = '0;

        repeat (3) @(negedge clk);
        check("R1", rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset
        rd(ad(2'd0, 0), "R1");
        rd(ad(2'd1, 37), "R1");
        rd(ad(2'd3, 0), "R1");
        rd(ad(2'd3, 1), "R1");

        // R2 / R10: configuration word write then next-cycle read
        wr(ad(2'd0, 3), 32'hA1B2_C3D4);
        rd(ad(2'd0, 3), "R10");
        rd(ad(2'd0, 2), "R2");
        wr(ad(2'd0, 9), 32'h0102_0304);
        rd(ad(2'd0, 9), "R2");

        // R3: single flip-flop access
        wr(ad(2'd1, 10), 32'h0000_0001);
        rd(ad(2'd1, 10), "R3");
        wr(ad(2'd1, 11), 32'hFFFF_FFFE);
        rd(ad(2'd1, 11), "R3");

        // R8: row-select register
        wr(ad(2'd3, 0), 32'hFFFF_FFA5);
        rd(ad(2'd3, 0), "R8");
        rd(ad(2'd3, 5), "R8");

        // R4: column 2 read with sparse rows selected
        wr(ad(2'd1, 0*8 + 2), 1);
        wr(ad(2'd1, 1*8 + 2), 1);
        wr(ad(2'd1, 5*8 + 2), 1);
        wr(ad(2'd1, 7*8 + 2), 1);
        rd(ad(2'd2, 2), "R4");
        wr(ad(2'd3, 0), 32'h0000_0080);
        rd(ad(2'd2, 2), "R4");
        wr(ad(2'd3, 0), 32'h0000_00A5);

        // R5: column scatter, unmapped row 1 keeps its 1
        wr(ad(2'd2, 2), 32'h0000_0005);
        rd(ad(2'd1, 1*8 + 2), "R5");
        rd(ad(2'd1, 0*8 + 2), "R5");
        rd(ad(2'd1, 2*8 + 2), "R5");
        rd(ad(2'd1, 5*8 + 2), "R5");
        rd(ad(2'd2, 2), "R5");

        // R7: distinct words, then reads with don't-care bits set
        wr(ad(2'd0, 0), 32'h1111_1111);
        wr(ad(2'd0, 1), 32'h2222_2222);
        wr(ad(2'd3, 1), 32'h0000_0001);
        rd(ad(2'd0, 0), "R7");
        rd(ad(2'd0, 1), "R7");
        rd(ad(2'd3, 1), "R8");

        // R6: configuration broadcast over words 4..7
        wr(ad(2'd3, 1), 32'h0000_0003);
        wr(ad(2'd0, 4), 32'hDEAD_BEEF);
        for (int w = 4; w < 9; w++) rd(ad(2'd0, w), "R6");

        // R6: flip-flop broadcast down column 3
        wr(ad(2'd3, 1), 32'h0000_0038);
        wr(ad(2'd1, 3), 32'h0000_0001);
        wr(ad(2'd3, 0), 32'h0000_00FF);
        rd(ad(2'd2, 3), "R6");
        rd(ad(2'd2, 4), "R6");

        // R6: column broadcast over all columns, rows 0..3
        wr(ad(2'd3, 0), 32'h0000_000F);
        wr(ad(2'd3, 1), 32'h0000_0007);
        wr(ad(2'd2, 0), 32'h0000_000A);
        rd(ad(2'd2, 6), "R6");
        rd(ad(2'd2, 1), "R6");

        // R8: control writes ignore don't-care bits
        wr(ad(2'd3, 1), 32'h0000_0001);
        wr(ad(2'd3, 1), 32'h0000_0021);
        rd(ad(2'd3, 0), "R8");
        rd(ad(2'd3, 1), "R8");

        // R11: out-of-range word and column
        wr(ad(2'd3, 1), 32'h0000_0000);
        wr(ad(2'd0, 20), 32'hCAFE_F00D);
        rd(ad(2'd0, 20), "R11");
        wr(ad(2'd2, 12), 32'hFFFF_FFFF);
        rd(ad(2'd2, 12), "R11");
        rd(ad(2'd2, 0), "R11");

        // R6: random mix including don't-care changes
        for (int n = 0; n < 400; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[3:0] == 4'd0) wr(ad(2'd3, 1), {26'd0, rv[9:4] & 6'h1B});
            else if (rv[3:0] == 4'd1) wr(ad(2'd3, 0), {24'd0, rv[11:4]});
            else if (rv[4]) wr({rv[6:5] == 2'd3 ? 2'd1 : rv[6:5], rv[12:7]}, $urandom);
            else rd({rv[6:5], rv[12:7]}, "R6");
        end

        // final sweep against the model
        wr(ad(2'd3, 1), 32'h0000_0000);
        for (int w = 0; w < WORDS; w++) rd(ad(2'd0, w), "R2");
        for (int i = 0; i < CELLS; i++) rd(ad(2'd1, i), "R3");
        for (int c = 0; c < COLS; c++) rd(ad(2'd2, c), "R4");

        idle(3);
        if (exp_q.size() != 0) check("scoreboard", 32'(exp_q.size()), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule